// File: doc/BRIEF.md
# Command Queue Packet Engine

This block turns one command held in a small word queue into a byte stream for a serial display link. Software fills the queue and a size register over a simple word-addressed register bus, then writes the start register. The engine sends a three-byte packet header, then the payload if the packet is long. If the command asks for a read, it hands the bus over to the panel and collects the panel's response bytes into four receive words. ECC, CRC and the physical lane layer are not part of this block. The header goes out as plain bytes and a downstream stage adds the checksums.

Queue word 0 is the descriptor. Bits 7:0 hold the configuration byte, bits 15:8 the data type, and bits 31:16 hold either two short-packet parameter bytes or a 16-bit long-packet word count. Long-packet payload starts at queue word 1, which is byte offset 4. The bytes of each word go out least significant first.

The sequencer has six states. `ST_IDLE` moves to `ST_HDR` on an accepted start. `ST_HDR` moves to `ST_BODY` when the payload length is nonzero. Otherwise it moves to `ST_TURN` for a read, or back to `ST_IDLE` when the packet is done. `ST_BODY` moves to `ST_TURN` or `ST_IDLE` after its last byte. `ST_TURN` lasts one cycle and moves to `ST_RECV`. `ST_RECV` moves to `ST_HOLD` when capture ends. `ST_HOLD` moves back to `ST_IDLE` on a receive acknowledge.

Top module: `cmdq_pkt_engine`

Register map (word addresses on `bus_addr`):

| Address | Access | Contents |
|---|---|---|
| 0x00 | write | start |
| 0x01 | read/write | interrupt enable, bits 1:0 |
| 0x02 | read/write | status: bit 0 read-ready, bit 1 command-done, bit 31 busy |
| 0x03 | read/write | mode, bits 1:0 (0 is command mode) |
| 0x04 | read/write | queue size, bits 5:0 |
| 0x05 | write | receive acknowledge |
| 0x08 to 0x0B | read | receive words |
| 0x80 + i | read/write | queue word i |

## Requirements
- R1: After reset, status (address 0x02) reads 0, `tx_valid` is 0, `tx_turn` is 0 and `irq` is 0.
- R2: When configuration bits 1 and 2 are both 0 (value 0 is the short packet), the engine sends exactly three bytes: the data type, then descriptor bits 23:16, then bits 31:24. It then sets command-done (status bit 1) and clears busy.
- R3: When configuration bit 1 is set (value 2 is the long packet), the header is the data type, then the word count low byte, then the word count high byte. The header is followed by the payload bytes. Payload byte k is taken from queue word 1+k/4, bits 8*(k%4)+7 down to 8*(k%4).
- R4: The number of payload bytes sent is the smaller of the word count and (queue size − 1)·4. A queue size of 0 sends no payload bytes. The header always carries the unmodified word count.
- R5: When configuration bit 2 is set, the engine pulses `tx_turn` for exactly one cycle after the last transmitted byte. It then clears all receive bytes and captures incoming `rx_data` bytes in order. Byte k lands in the receive word at address 0x08+k/4, bits 8*(k%4)+7 down to 8*(k%4). Capture ends on a byte flagged `rx_last` or on the 16th byte, whichever comes first. Later bytes are ignored.
- R6: When capture ends, read-ready (bit 0) and command-done (bit 1) are both set in the same cycle. Busy stays set until a write of bit 0 = 1 to address 0x05.
- R7: Status bit 31 reads 1 from the cycle after an accepted start until the command finishes. A start (write to address 0x00 with bit 0 = 1) issued while busy is ignored: no bytes are sent and the status is unchanged.
- R8: A start is ignored while the mode register (address 0x03, bits 1:0) is nonzero.
- R9: A write to address 0x02 clears each status bit whose written bit is 0 and keeps each bit written 1. A set event in the same cycle wins over the clear.
- R10: `irq` is the OR of status bits 1:0 masked by the enable register (address 0x01, bits 1:0).
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Word address for register reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tx_valid | output | 1 | Byte available on `tx_data` |
| tx_data | output | 8 | Outgoing packet byte |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| tx_turn | output | 1 | One-cycle request to hand the link to the panel |
| rx_valid | input | 1 | Response byte present |
| rx_data | input | 8 | Response byte |
| rx_last | input | 1 | Marks the final response byte |
| irq | output | 1 | Enabled status summary |

## Verification
The assertions assume the following about the inputs:
- Software does not rewrite the queue or the size register while busy is set. Payload bytes are fetched live, so the held-byte check relies on this.
- Response bytes arrive only after `tx_turn`.
- For a read, either `rx_last` or a sixteenth byte eventually arrives.

The stimulus stays inside these assumptions. Every queue write comes before its start. The responder waits one cycle after seeing the turnaround pulse before it drives bytes. Read responses shorter than sixteen bytes always carry `rx_last`. Within these limits, `tx_ready` back-pressure, configuration, size, word count and response length are random.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned WC_W   = 16;

    localparam logic [BUS_AW-1:0] A_GO   = 8'h00;
    localparam logic [BUS_AW-1:0] A_IEN  = 8'h01;
    localparam logic [BUS_AW-1:0] A_STAT = 8'h02;
    localparam logic [BUS_AW-1:0] A_MODE = 8'h03;
    localparam logic [BUS_AW-1:0] A_QSZ  = 8'h04;
    localparam logic [BUS_AW-1:0] A_RACK = 8'h05;
    localparam logic [BUS_AW-1:0] A_RX0  = 8'h08;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_TURN,
        ST_RECV,
        ST_HOLD
    } seq_state_e;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int unsigned QDEPTH = 64,
    localparam int unsigned QIW = $clog2(QDEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BUS_AW-1:0] wr_addr,
    input  logic [BUS_DW-1:0] wr_data,
    input  logic [QIW-1:0]    seq_idx,
    input  logic [QIW-1:0]    bus_idx,
    output logic [BUS_DW-1:0] word0,
    output logic [BUS_DW-1:0] seq_word,
    output logic [BUS_DW-1:0] bus_word,
    output logic [QIW-1:0]    qsize,
    output logic [1:0]        mode,
    output logic [1:0]        inten
);
    // queue window: address bits 7:6 equal to 2'b10
    logic [BUS_DW-1:0] qmem [QDEPTH];
    logic              q_hit;

    assign q_hit = wr_en && (wr_addr[BUS_AW-1:BUS_AW-2] == 2'b10);

    always_ff @(posedge clk) begin
        if (q_hit) begin
            qmem[wr_addr[QIW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qsize <= '0;
            mode  <= '0;
            inten <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_QSZ)  qsize <= wr_data[QIW-1:0];
            if (wr_addr == A_MODE) mode  <= wr_data[1:0];
            if (wr_addr == A_IEN)  inten <= wr_data[1:0];
        end
    end

    assign word0    = qmem[0];
    assign seq_word = qmem[seq_idx];
    assign bus_word = qmem[bus_idx];
endmodule

// File: rtl/cmdq_rxcap.sv
module cmdq_rxcap #(
    parameter int unsigned RX_BYTES = 16,
    localparam int unsigned CW = $clog2(RX_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  take,
    input  logic [7:0]            din,
    output logic                  at_last,
    output logic [RX_BYTES*8-1:0] rx_flat
);
    logic [7:0]    rb [RX_BYTES];
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (take && (cnt_q < CW'(RX_BYTES))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar g = 0; g < RX_BYTES; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rb[g] <= '0;
            end else if (clr) begin
                rb[g] <= '0;
            end else if (take && (cnt_q == CW'(g))) begin
                rb[g] <= din;
            end
        end
        assign rx_flat[g*8 +: 8] = rb[g];
    end

    assign at_last = (cnt_q == CW'(RX_BYTES - 1));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(RX_BYTES));
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
    import cmdq_pkg::*;
#(
    parameter int unsigned QIW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              mode_cmd,
    input  logic              ack,
    input  logic [BUS_DW-1:0] word0,
    input  logic [BUS_DW-1:0] rd_word,
    input  logic [QIW-1:0]    qsize,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic              rx_last,
    input  logic              rx_at_last,
    output logic [QIW-1:0]    rd_idx,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_turn,
    output logic              busy,
    output logic              set_done,
    output logic              set_rdy,
    output logic              rx_clr,
    output logic              rx_take
);
    seq_state_e      state_q, state_d;
    logic [1:0]      hdr_q;
    logic [WC_W-1:0] cnt_q, len_q, hi_q;
    logic [7:0]      dt_q;
    logic            turn_q;

    logic            go, fire, hdr_end, body_end, recv_end;
    logic [WC_W-1:0] lim, wc, blen;
    logic            unused_cfg;

    assign unused_cfg = ^{word0[7:3], word0[0]};

    assign go   = (state_q == ST_IDLE) && start_req && mode_cmd;
    assign fire = tx_valid && tx_ready;
    assign wc   = word0[31:16];
    assign lim  = (qsize == '0) ? '0 : {{(WC_W-QIW-2){1'b0}}, qsize - 1'b1, 2'b00};
    assign blen = word0[1] ? ((wc < lim) ? wc : lim) : '0;

    assign hdr_end  = (state_q == ST_HDR) && fire && (hdr_q == 2'd2);
    assign body_end = (state_q == ST_BODY) && fire && (cnt_q == len_q - 1'b1);
    assign recv_end = (state_q == ST_RECV) && rx_valid && (rx_last || rx_at_last);

    // state register and command latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hdr_q   <= '0;
            cnt_q   <= '0;
            len_q   <= '0;
            hi_q    <= '0;
            dt_q    <= '0;
            turn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (go) begin
                dt_q   <= word0[15:8];
                hi_q   <= wc;
                len_q  <= blen;
                turn_q <= word0[2];
                hdr_q  <= '0;
                cnt_q  <= '0;
            end else if ((state_q == ST_HDR) && fire) begin
                hdr_q <= hdr_q + 1'b1;
            end else if ((state_q == ST_BODY) && fire) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_HDR;
            ST_HDR:  if (hdr_end)
                         state_d = (len_q != '0) ? ST_BODY : (turn_q ? ST_TURN : ST_IDLE);
            ST_BODY: if (body_end) state_d = turn_q ? ST_TURN : ST_IDLE;
            ST_TURN: state_d = ST_RECV;
            ST_RECV: if (recv_end) state_d = ST_HOLD;
            ST_HOLD: if (ack) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_valid = (state_q == ST_HDR) || (state_q == ST_BODY);
        tx_turn  = (state_q == ST_TURN);
        busy     = (state_q != ST_IDLE);
        rx_clr   = (state_q == ST_TURN);
        rx_take  = (state_q == ST_RECV) && rx_valid;
        set_rdy  = recv_end;
        set_done = (hdr_end && (len_q == '0) && !turn_q) || (body_end && !turn_q) || recv_end;
        rd_idx   = QIW'(1) + cnt_q[QIW+1:2];
        tx_data  = '0;
        if (state_q == ST_HDR) begin
            unique case (hdr_q)
                2'd0:    tx_data = dt_q;
                2'd1:    tx_data = hi_q[7:0];
                default: tx_data = hi_q[15:8];
            endcase
        end else if (state_q == ST_BODY) begin
            tx_data = rd_word[8*cnt_q[1:0] +: 8];
        end
    end

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R5
    turn_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_turn |=> !tx_turn);
    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !ack) |=> (state_q == ST_HOLD));
    // R8
    mode_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_req && !mode_cmd) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/cmdq_pkt_engine.sv
module cmdq_pkt_engine
    import cmdq_pkg::*;
#(
    parameter int unsigned QDEPTH   = 64,
    parameter int unsigned RX_BYTES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    output logic        tx_turn,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    output logic        irq
);
    localparam int unsigned QIW = $clog2(QDEPTH);
    localparam int unsigned RXW = RX_BYTES / 4;

    logic [BUS_DW-1:0]     word0, seq_word, bus_word;
    logic [QIW-1:0]        qsize, rd_idx;
    logic [1:0]            mode, inten, sts_q;
    logic                  start_req, ack, wr_stat, busy;
    logic                  set_done, set_rdy, rx_clr, rx_take, rx_at_last;
    logic [RX_BYTES*8-1:0] rx_flat;

    assign start_req = bus_wr && (bus_addr == A_GO) && bus_wdata[0];
    assign ack       = bus_wr && (bus_addr == A_RACK) && bus_wdata[0];
    assign wr_stat   = bus_wr && (bus_addr == A_STAT);

    cmdq_regs #(.QDEPTH(QDEPTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .seq_idx  (rd_idx),
        .bus_idx  (bus_addr[QIW-1:0]),
        .word0    (word0),
        .seq_word (seq_word),
        .bus_word (bus_word),
        .qsize    (qsize),
        .mode     (mode),
        .inten    (inten)
    );

    cmdq_seq #(.QIW(QIW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (start_req),
        .mode_cmd   (mode == 2'd0),
        .ack        (ack),
        .word0      (word0),
        .rd_word    (seq_word),
        .qsize      (qsize),
        .tx_ready   (tx_ready),
        .rx_valid   (rx_valid),
        .rx_last    (rx_last),
        .rx_at_last (rx_at_last),
        .rd_idx     (rd_idx),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_turn    (tx_turn),
        .busy       (busy),
        .set_done   (set_done),
        .set_rdy    (set_rdy),
        .rx_clr     (rx_clr),
        .rx_take    (rx_take)
    );

    cmdq_rxcap #(.RX_BYTES(RX_BYTES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .take    (rx_take),
        .din     (rx_data),
        .at_last (rx_at_last),
        .rx_flat (rx_flat)
    );

    // status: bit 0 read-ready, bit 1 command-done; sets win over clears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (wr_stat ? (sts_q & bus_wdata[1:0]) : sts_q) | {set_done, set_rdy};
        end
    end

    assign irq = |(sts_q & inten);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[7:6] == 2'b10) begin
            bus_rdata = bus_word;
        end else if (bus_addr == A_IEN) begin
            bus_rdata = {30'b0, inten};
        end else if (bus_addr == A_STAT) begin
            bus_rdata = {busy, 29'b0, sts_q};
        end else if (bus_addr == A_MODE) begin
            bus_rdata = {30'b0, mode};
        end else if (bus_addr == A_QSZ) begin
            bus_rdata = {{(32-QIW){1'b0}}, qsize};
        end
        for (int w = 0; w < RXW; w++) begin
            if (bus_addr == A_RX0 + 8'(w)) bus_rdata = rx_flat[w*32 +: 32];
        end
    end

    // R6
    rdy_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[0]) |-> sts_q[1]);
endmodule

// File: tb/tb_cmdq_pkt_engine.sv
`timescale 1ns/1ps
module tb_cmdq_pkt_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_turn, irq;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int turns = 0;
    int stall_err = 0;
    bit stall_pend = 1'b0;
    logic [7:0] stall_data;
    logic [7:0] got[$];
    logic [7:0] exp_q[$];
    logic [31:0] qm [64];

    always #2 clk = ~clk;

    cmdq_pkt_engine dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .tx_turn(tx_turn),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .irq(irq)
    );

    // byte sink with random back-pressure; sampled between edges
    always @(negedge clk) begin
        if (!rst_n) begin
            tx_ready = 1'b0;
            stall_pend = 1'b0;
        end else begin
            if (stall_pend && !(tx_valid && tx_data == stall_data)) stall_err++;
            tx_ready = (($urandom % 4) != 0);
            stall_pend = tx_valid && !tx_ready;
            stall_data = tx_data;
            if (tx_valid && tx_ready) got.push_back(tx_data);
            if (tx_turn) turns++;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    function automatic int lim_of(input int qs);
        return (qs == 0) ? 0 : (qs - 1) * 4;
    endfunction

    task automatic wait_idle(output logic [31:0] st);
        st = 32'h8000_0000;
        for (int i = 0; i < 3000 && st[31]; i++) bus_read(8'h02, st);
    endtask

    task automatic cmp_bytes(input string req);
        bit ok = (got.size() == exp_q.size());
        int bad = -1;
        if (ok) begin
            foreach (exp_q[i]) if (got[i] !== exp_q[i] && bad < 0) bad = i;
            ok = (bad < 0);
        end
        if (!ok && bad >= 0) check(1'b0, req, 32'(got[bad]), 32'(exp_q[bad]));
        else check(ok, req, 32'(got.size()), 32'(exp_q.size()));
    endtask

    task automatic do_cmd(input logic [7:0] cfg, input logic [7:0] dt, input logic [15:0] hi,
                          input int qs, input int nrx, input bit use_last, input bit poke);
        logic [31:0] st, rw;
        logic [7:0]  rxb [32];
        int n, cap, got_n;
        string req;
        for (int w = 1; w < qs; w++) begin
            qm[w] = $urandom;
            bus_write(8'h80 + 8'(w), qm[w]);
        end
        qm[0] = {hi, dt, cfg};
        bus_write(8'h80, qm[0]);
        bus_write(8'h04, 32'(qs));
        bus_write(8'h02, 32'h0);
        exp_q.delete();
        exp_q.push_back(dt); exp_q.push_back(hi[7:0]); exp_q.push_back(hi[15:8]);
        n = 0;
        if (cfg[1]) n = (int'(hi) < lim_of(qs)) ? int'(hi) : lim_of(qs);
        for (int k = 0; k < n; k++) exp_q.push_back(qm[1 + k/4][8*(k%4) +: 8]);
        req = !cfg[1] ? "R2" : ((int'(hi) > lim_of(qs)) ? "R4" : "R3");
        got.delete(); turns = 0;
        bus_write(8'h00, 32'h1);
        bus_read(8'h02, st);
        check(st[31] === 1'b1, "R7 busy after start", st, 32'h8000_0000);
        if (cfg[2]) begin
            for (int i = 0; i < 3000 && turns == 0; i++) begin
                @(negedge clk); #1;
            end
            check(turns == 1, "R5 single turnaround pulse", 32'(turns), 32'd1);
            for (int k = 0; k < nrx; k++) begin
                @(negedge clk);
                rxb[k] = 8'($urandom);
                rx_valid = 1'b1; rx_data = rxb[k];
                rx_last = use_last && (k == nrx - 1);
            end
            @(negedge clk);
            rx_valid = 1'b0; rx_last = 1'b0;
            cap = (nrx < 16) ? nrx : 16;
            bus_read(8'h02, st);
            check(st === 32'h8000_0003, "R6 flags set and busy held", st, 32'h8000_0003);
            cmp_bytes({req, " read header/payload"});
            for (int w = 0; w < 4; w++) begin
                logic [31:0] e = '0;
                for (int b = 0; b < 4; b++) if (w*4 + b < cap) e[8*b +: 8] = rxb[w*4 + b];
                bus_read(8'h08 + 8'(w), rw);
                check(rw === e, "R5 receive word", rw, e);
            end
            if (poke) begin
                got_n = got.size();
                bus_write(8'h00, 32'h1);
                repeat (10) @(negedge clk);
                bus_read(8'h02, st);
                check(st === 32'h8000_0003 && got.size() == got_n, "R7 start while busy ignored", st, 32'h8000_0003);
            end
            bus_write(8'h05, 32'h1);
            bus_read(8'h02, st);
            check(st === 32'h0000_0003, "R6 ack releases busy", st, 32'h3);
        end else begin
            wait_idle(st);
            check(st === 32'h2, {req, " done status"}, st, 32'h2);
            cmp_bytes(req);
            check(turns == 0, {req, " no turnaround"}, 32'(turns), 32'd0);
        end
    endtask

    initial begin
        logic [31:0] st;
        logic [7:0] cfg;
        int nrx, qs;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        bus_read(8'h02, st);
        check(st === 32'h0, "R1 status after reset", st, 32'h0);
        check(tx_valid === 1'b0 && tx_turn === 1'b0 && irq === 1'b0, "R1 outputs idle",
              {29'b0, tx_valid, tx_turn, irq}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        do_cmd(8'h00, 8'h05, 16'hBEEF, 1, 0, 1'b1, 1'b0);
        do_cmd(8'h02, 8'h39, 16'd9, 4, 0, 1'b1, 1'b0);
        do_cmd(8'h02, 8'h29, 16'd20, 3, 0, 1'b1, 1'b0);
        do_cmd(8'h02, 8'h29, 16'd5, 0, 0, 1'b1, 1'b0);
        do_cmd(8'h02, 8'h39, 16'd0, 4, 0, 1'b1, 1'b0);
        do_cmd(8'h04, 8'h06, 16'h000A, 1, 3, 1'b1, 1'b1);
        do_cmd(8'h04, 8'h14, 16'h0001, 1, 20, 1'b0, 1'b0);
        do_cmd(8'h06, 8'h24, 16'd6, 3, 16, 1'b0, 1'b0);

        // R9 status write semantics, R10 interrupt masking
        do_cmd(8'h00, 8'h15, 16'h1234, 1, 0, 1'b1, 1'b0);
        bus_write(8'h02, 32'hFFFF_FFFF);
        bus_read(8'h02, st);
        check(st === 32'h2, "R9 writing ones keeps status", st, 32'h2);
        bus_write(8'h01, 32'h2);
        @(negedge clk);
        check(irq === 1'b1, "R10 irq with done enabled", 32'(irq), 32'd1);
        bus_write(8'h01, 32'h1);
        @(negedge clk);
        check(irq === 1'b0, "R10 irq masked", 32'(irq), 32'd0);
        bus_write(8'h02, 32'h0);
        bus_read(8'h02, st);
        check(st === 32'h0, "R9 writing zero clears", st, 32'h0);
        do_cmd(8'h04, 8'h06, 16'h00DA, 1, 2, 1'b1, 1'b0);
        @(negedge clk);
        check(irq === 1'b1, "R10 irq from read-ready", 32'(irq), 32'd1);
        bus_write(8'h01, 32'h0);

        // R8 start blocked outside command mode
        bus_write(8'h03, 32'h1);
        bus_write(8'h02, 32'h0);
        got.delete(); turns = 0;
        bus_write(8'h00, 32'h1);
        repeat (10) @(negedge clk);
        bus_read(8'h02, st);
        check(st === 32'h0 && got.size() == 0, "R8 start ignored in video mode", st, 32'h0);
        bus_write(8'h03, 32'h0);

        // random commands
        for (int t = 0; t < 40; t++) begin
            case ($urandom % 4)
                0: cfg = 8'h00;
                1: cfg = 8'h02;
                2: cfg = 8'h04;
                default: cfg = 8'h06;
            endcase
            qs = $urandom % 9;
            nrx = 1 + ($urandom % 20);
            do_cmd(cfg, 8'($urandom), cfg[1] ? 16'($urandom % 40) : 16'($urandom),
                   qs, nrx, (nrx < 16) ? 1'b1 : 1'($urandom), 1'b0);
        end

        check(stall_err == 0, "R11 byte held under back-pressure", 32'(stall_err), 32'd0);
        summary();
    end
endmodule